// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block serves the vector configure operation of a small vector unit whose registers are 128 bits wide. Each request carries an application vector length and a type word. The unit checks the type word against a small fixed set of legal configurations and returns the number of elements granted. It holds the granted length, the accepted type word and an illegal-configuration flag until the next request.

Software from two generations uses different bit layouts for the type word. A mode input selects which layout to decode: the ratified layout or the older draft layout. Only 8-, 16- and 32-bit elements and integral register grouping factors of 1, 2, 4 and 8 are accepted. Fractional grouping, the older layout's element-divide bits and any stray high bit each make the request illegal. An illegal request clears the length and raises the flag. The flag stays set until a legal request arrives.

The maximum length for a configuration is 128 × grouping ÷ element width. For example, 8-bit elements with grouping 1 give 16 elements. The grant is the smaller of the requested length and this maximum. Two flags tell the unit when the length source is the zero register and when the destination is the zero register.

Top module: `vcfg_unit`

## Requirements
- R1: While `rst_n` is low, at each clock edge the unit sets `vl_q` to 0, `bad_cfg_q` to 1 and `type_q` to 0x80000000.
- R2: All outputs change only at the clock edge that samples `cfg_valid` high. With `cfg_valid` low they hold their values, whatever the other inputs do.
- R3: Ratified layout (`fmt_legacy`=0). Grouping code is bits [2:0]: 0,1,2,3 mean 1,2,4,8, and 4 to 7 (fractional) are illegal. Width code is bits [5:3]. Bits 6 and 7 are policy bits and may take any value.
- R4: Legacy layout (`fmt_legacy`=1). Grouping code is bits [1:0]: 0,1,2,3 mean 1,2,4,8. Width code is bits [4:2]. Bits [6:5] are the divide field and must be 0. A type word with 8-bit elements decodes the same in both layouts.
- R5: In both layouts the width codes 0, 1 and 2 mean 8, 16 and 32 bits. Codes 3 to 7 are illegal.
- R6: In the ratified layout any grouping code from 4 to 7 is illegal.
- R7: A set bit above the layout's defined fields is illegal. That is bits [31:8] in the ratified layout and bits [31:7] in the legacy layout.
- R8: With `avl_is_x0`=0 a legal request grants `vl_q` = min(`req_avl`, VLMAX), where VLMAX = 128 × LMUL / SEW.
- R9: With `avl_is_x0`=1 and `dst_is_x0`=0, a legal request grants VLMAX.
- R10: With `avl_is_x0`=1 and `dst_is_x0`=1, a legal request grants min(previous `vl_q`, VLMAX).
- R11: An illegal request sets `bad_cfg_q`=1, `vl_q`=0 and `type_q`=0x80000000. These values hold until the next legal request.
- R12: A legal request clears `bad_cfg_q` and loads `type_q` with `req_type` exactly as given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Configure request strobe |
| fmt_legacy | input | 1 | Type-word layout: 0 ratified, 1 legacy |
| req_avl | input | 32 | Requested application vector length |
| req_type | input | 32 | Requested type word |
| avl_is_x0 | input | 1 | Length source is the zero register |
| dst_is_x0 | input | 1 | Destination is the zero register |
| vl_q | output | 32 | Granted vector length |
| type_q | output | 32 | Accepted type word, or top bit only when illegal |
| bad_cfg_q | output | 1 | Illegal-configuration flag |

## Verification
Every result of a request is due at the first rising edge that samples `cfg_valid` high. The bench drives inputs on the falling edge and drops the strobe at the next falling edge, then checks all three outputs at that falling edge, half a cycle after they settle. For hold and sticky-flag behaviour, it changes the inputs with the strobe low and checks again one and several cycles later. The sweep covers every width and grouping code in both layouts against several lengths on each side of VLMAX.

// File: rtl/vcfg_pkg.sv
// Package: shared types for the vector length configuration unit.
// Assumes element widths are powers of two, so scaling is done by shifts.
package vcfg_pkg;

    // Decoded type word: legality plus log2 of element width and grouping
    typedef struct packed {
        logic       legal;
        logic [2:0] sew_sh;   // log2(SEW in bits): 3, 4 or 5
        logic [1:0] lmul_sh;  // log2(LMUL): 0..3
        logic [1:0] pol;      // policy bits (ratified layout only)
    } vcfg_dec_t;

    localparam int unsigned SEW_CODES = 3;  // legal width codes 0..2

endpackage

// File: rtl/vcfg_decode.sv
// Module: vcfg_decode
// Decodes one type-word layout into element width, grouping and legality.
// LEGACY=0 picks the ratified layout, LEGACY=1 the older draft layout.
// Assumes XLEN >= 9 so both layouts have a reserved upper region.
module vcfg_decode
    import vcfg_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter bit          LEGACY = 1'b0
) (
    input  logic [XLEN-1:0] type_word,
    output vcfg_dec_t       dec
);

    generate
        if (LEGACY) begin : g_legacy
            logic [1:0] lmul_f;
            logic [2:0] sew_f;
            logic [1:0] div_f;
            logic       upper_ok;

            // Slice the legacy fields: grouping low, width above it, divide bits next
            always_comb begin
                lmul_f   = type_word[1:0];
                sew_f    = type_word[4:2];
                div_f    = type_word[6:5];
                upper_ok = (type_word[XLEN-1:7] == '0);
            end

            // Legality and log2 scaling for the legacy layout
            always_comb begin
                dec.legal   = (sew_f < 3'(SEW_CODES)) && (div_f == 2'b00) && upper_ok;
                dec.sew_sh  = sew_f + 3'd3;
                dec.lmul_sh = lmul_f;
                dec.pol     = 2'b00;
            end
        end else begin : g_ratified
            logic [2:0] lmul_f;
            logic [2:0] sew_f;
            logic       upper_ok;

            // Slice the ratified fields: three contiguous grouping bits, width, policy
            always_comb begin
                lmul_f   = type_word[2:0];
                sew_f    = type_word[5:3];
                upper_ok = (type_word[XLEN-1:8] == '0);
            end

            // Legality and log2 scaling; grouping codes with bit 2 set are fractional
            always_comb begin
                dec.legal   = (sew_f < 3'(SEW_CODES)) && !lmul_f[2] && upper_ok;
                dec.sew_sh  = sew_f + 3'd3;
                dec.lmul_sh = lmul_f[1:0];
                dec.pol     = type_word[7:6];
            end
        end
    endgenerate

endmodule

// File: rtl/vcfg_len.sv
// Module: vcfg_len
// Computes VLMAX from decoded scaling and picks the granted length.
// Assumes a legal decode; the caller discards the result when illegal.
module vcfg_len #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned VLEN = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      sew_sh,
    input  logic [1:0]      lmul_sh,
    input  logic [XLEN-1:0] avl,
    input  logic [XLEN-1:0] prev_vl,
    input  logic            avl_is_x0,
    input  logic            dst_is_x0,
    output logic [XLEN-1:0] vlmax,
    output logic [XLEN-1:0] vl_next
);

    logic [XLEN-1:0] target;

    // Scale the register width by grouping, divide by element width
    always_comb begin
        vlmax = (XLEN'(VLEN) << lmul_sh) >> sew_sh;
    end

    // Choose the requested length source, then clip to VLMAX
    always_comb begin
        if (!avl_is_x0)     target = avl;
        else if (dst_is_x0) target = prev_vl;
        else                target = vlmax;
        vl_next = (target < vlmax) ? target : vlmax;
    end

    // R8: the grant never exceeds VLMAX
    p_vl_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vl_next <= vlmax);

    // R9: zero source with live destination grants exactly VLMAX
    p_max_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (avl_is_x0 && !dst_is_x0) |-> vl_next == vlmax);

endmodule

// File: rtl/vcfg_unit.sv
// Module: vcfg_unit (top)
// Accepts a configure request, checks the type word in the selected layout,
// and registers the granted length, accepted type word and illegal flag.
// Assumes one request per strobe; results appear at the sampling edge.
module vcfg_unit
    import vcfg_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    parameter int unsigned VLEN = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_valid,
    input  logic            fmt_legacy,
    input  logic [XLEN-1:0] req_avl,
    input  logic [XLEN-1:0] req_type,
    input  logic            avl_is_x0,
    input  logic            dst_is_x0,
    output logic [XLEN-1:0] vl_q,
    output logic [XLEN-1:0] type_q,
    output logic            bad_cfg_q
);

    localparam int unsigned N_FMT = 2;
    localparam logic [XLEN-1:0] ILL_WORD = {1'b1, {(XLEN-1){1'b0}}};

    vcfg_dec_t       dec_all [N_FMT];
    vcfg_dec_t       dec_sel;
    logic [XLEN-1:0] vlmax;
    logic [XLEN-1:0] vl_next;

    // One decoder per layout; index equals the mode value
    for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
        vcfg_decode #(.XLEN(XLEN), .LEGACY(g == 1)) u_dec (
            .type_word (req_type),
            .dec       (dec_all[g])
        );
    end

    // Select the decode for the requested layout
    always_comb begin
        dec_sel = dec_all[fmt_legacy];
    end

    vcfg_len #(.XLEN(XLEN), .VLEN(VLEN)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .sew_sh    (dec_sel.sew_sh),
        .lmul_sh   (dec_sel.lmul_sh),
        .avl       (req_avl),
        .prev_vl   (vl_q),
        .avl_is_x0 (avl_is_x0),
        .dst_is_x0 (dst_is_x0),
        .vlmax     (vlmax),
        .vl_next   (vl_next)
    );

    // State update: reset, accept a legal request, or flag an illegal one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q      <= '0;
            type_q    <= ILL_WORD;
            bad_cfg_q <= 1'b1;
        end else if (cfg_valid) begin
            if (dec_sel.legal) begin
                vl_q      <= vl_next;
                type_q    <= req_type;
                bad_cfg_q <= 1'b0;
            end else begin
                vl_q      <= '0;
                type_q    <= ILL_WORD;
                bad_cfg_q <= 1'b1;
            end
        end
    end

    // R1: reset state
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (vl_q == '0) && bad_cfg_q && (type_q == ILL_WORD));

    // R2: no strobe, no change
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> $stable(vl_q) && $stable(type_q) && $stable(bad_cfg_q));

    // R11: illegal state always carries a zero length and the marker word
    p_ill_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cfg_q |-> (vl_q == '0) && (type_q == ILL_WORD));

    // R12: a legal request stores the word as given
    p_ok_type_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && dec_sel.legal) |=> !bad_cfg_q && (type_q == $past(req_type)));

    // R3: ratified policy bits pass through to the stored word
    p_policy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !fmt_legacy && dec_all[0].legal) |=> type_q[7:6] == $past(dec_all[0].pol));

    // R4: words with 8-bit elements and integral grouping decode alike in both layouts
    p_e8_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_type[XLEN-1:2] == '0) |->
            dec_all[0].legal && dec_all[1].legal &&
            (dec_all[0].sew_sh == dec_all[1].sew_sh) &&
            (dec_all[0].lmul_sh == dec_all[1].lmul_sh));

    // R8: stored length never exceeds the largest possible VLMAX
    p_vl_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vl_q <= XLEN'(VLEN));

endmodule

// File: tb/test_vcfg_unit.sv
// Bench: sweeps width and grouping codes in both layouts and checks
// the granted length, flag and stored word against arithmetic expectations.
module test_vcfg_unit;

    localparam int unsigned XLEN = 32;
    localparam logic [31:0] ILL_WORD = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic        fmt_legacy = 1'b0;
    logic [31:0] req_avl = '0;
    logic [31:0] req_type = '0;
    logic        avl_is_x0 = 1'b0;
    logic        dst_is_x0 = 1'b0;
    logic [31:0] vl_q;
    logic [31:0] type_q;
    logic        bad_cfg_q;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;   // 250 MHz

    vcfg_unit #(.XLEN(XLEN), .VLEN(128)) i_vcfg_unit (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .fmt_legacy(fmt_legacy),
        .req_avl(req_avl), .req_type(req_type), .avl_is_x0(avl_is_x0),
        .dst_is_x0(dst_is_x0), .vl_q(vl_q), .type_q(type_q), .bad_cfg_q(bad_cfg_q)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // Full output check for one expected state
    task automatic chk_state(input string tag, input logic [31:0] evl,
                             input logic [31:0] etype, input logic eill);
        chk({tag, " vl"}, vl_q, evl);
        chk({tag, " type"}, type_q, etype);
        chk({tag, " flag"}, {31'd0, bad_cfg_q}, {31'd0, eill});
    endtask

    // Drive one request for one cycle; outputs are checkable on return
    task automatic cfg(input logic legacy, input logic [31:0] word, input logic [31:0] avl,
                       input logic sz, input logic dz);
        @(negedge clk);
        fmt_legacy = legacy; req_type = word; req_avl = avl;
        avl_is_x0 = sz; dst_is_x0 = dz; cfg_valid = 1'b1;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    function automatic logic [31:0] vmax(input int sc, input int lc);
        return (128 * (1 << lc)) / (8 << sc);
    endfunction

    function automatic logic [31:0] umin(input logic [31:0] a, input logic [31:0] b);
        return (a < b) ? a : b;
    endfunction

    initial begin
        #(200000 * 4);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] avls [6];
        avls = '{32'd0, 32'd1, 32'd15, 32'd16, 32'd17, 32'd300};
        repeat (3) @(negedge clk);
        chk_state("R1 reset", 32'd0, ILL_WORD, 1'b1);
        rst_n = 1'b1;

        // R3 R5 R6 R8: ratified sweep over all width and grouping codes
        for (int sc = 0; sc < 8; sc++)
            for (int lc = 0; lc < 8; lc++)
                for (int a = 0; a < 6; a++) begin
                    logic [31:0] w;
                    w = 32'((sc << 3) | lc);
                    cfg(1'b0, w, avls[a], 1'b0, 1'b0);
                    if (sc < 3 && lc < 4)
                        chk_state("R3 R8 ratified legal", umin(avls[a], vmax(sc, lc)), w, 1'b0);
                    else
                        chk_state("R5 R6 ratified illegal", 32'd0, ILL_WORD, 1'b1);
                end

        // R4 R5 R8: legacy sweep
        for (int sc = 0; sc < 8; sc++)
            for (int lc = 0; lc < 4; lc++)
                for (int a = 0; a < 6; a++) begin
                    logic [31:0] w;
                    w = 32'((sc << 2) | lc);
                    cfg(1'b1, w, avls[a], 1'b0, 1'b0);
                    if (sc < 3)
                        chk_state("R4 R8 legacy legal", umin(avls[a], vmax(sc, lc)), w, 1'b0);
                    else
                        chk_state("R5 legacy illegal", 32'd0, ILL_WORD, 1'b1);
                end

        // R4: e8 words agree; e16 words do not
        cfg(1'b1, 32'h0, 32'd100, 1'b0, 1'b0);
        chk_state("R4 e8m1 legacy", 32'd16, 32'h0, 1'b0);
        cfg(1'b0, 32'h0, 32'd100, 1'b0, 1'b0);
        chk_state("R4 e8m1 ratified", 32'd16, 32'h0, 1'b0);
        cfg(1'b1, 32'h4, 32'd100, 1'b0, 1'b0);
        chk_state("R4 e16 legacy", 32'd8, 32'h4, 1'b0);
        cfg(1'b0, 32'h4, 32'd100, 1'b0, 1'b0);
        chk_state("R6 word4 ratified fractional", 32'd0, ILL_WORD, 1'b1);

        // R4: divide bits set
        cfg(1'b1, 32'h20, 32'd5, 1'b0, 1'b0);
        chk_state("R4 divide bit5", 32'd0, ILL_WORD, 1'b1);
        cfg(1'b1, 32'h40, 32'd5, 1'b0, 1'b0);
        chk_state("R4 divide bit6", 32'd0, ILL_WORD, 1'b1);

        // R3: policy bits accepted in ratified layout
        cfg(1'b0, 32'hC9, 32'd5, 1'b0, 1'b0);
        chk_state("R3 policy bits e16m2", 32'd5, 32'hC9, 1'b0);
        cfg(1'b1, 32'h80, 32'd5, 1'b0, 1'b0);
        chk_state("R7 legacy bit7", 32'd0, ILL_WORD, 1'b1);

        // R7: stray upper bits
        cfg(1'b0, 32'h8000_0000, 32'd5, 1'b0, 1'b0);
        chk_state("R7 ratified bit31", 32'd0, ILL_WORD, 1'b1);
        cfg(1'b0, 32'h100, 32'd5, 1'b0, 1'b0);
        chk_state("R7 ratified bit8", 32'd0, ILL_WORD, 1'b1);

        // R9: zero source, live destination -> VLMAX
        cfg(1'b0, 32'h13, 32'd3, 1'b1, 1'b0);
        chk_state("R9 e32m8 vlmax", 32'd32, 32'h13, 1'b0);
        cfg(1'b1, 32'h03, 32'd3, 1'b1, 1'b0);
        chk_state("R9 e8m8 vlmax", 32'd128, 32'h03, 1'b0);

        // R10: zero source and destination keep previous length, clipped
        cfg(1'b0, 32'h02, 32'd0, 1'b1, 1'b1);
        chk_state("R10 keep clipped to 64", 32'd64, 32'h02, 1'b0);
        cfg(1'b0, 32'h03, 32'd0, 1'b1, 1'b1);
        chk_state("R10 keep 64", 32'd64, 32'h03, 1'b0);

        // R2: inputs change without strobe
        @(negedge clk);
        req_type = 32'hFF; req_avl = 32'd1; fmt_legacy = 1'b1;
        @(negedge clk);
        chk_state("R2 hold", 32'd64, 32'h03, 1'b0);

        // R11: illegal flag sticks across idle cycles, cleared by a legal request
        cfg(1'b0, 32'h38, 32'd9, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        chk_state("R11 sticky", 32'd0, ILL_WORD, 1'b1);
        cfg(1'b0, 32'h08, 32'd0, 1'b1, 1'b1);
        chk_state("R10 R12 after illegal", 32'd0, 32'h08, 1'b0);

        // R1: reset again mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk_state("R1 re-reset", 32'd0, ILL_WORD, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule